// File: doc/BRIEF.md
# One-Time-Programmable Memory Page Programming Sequencer

This block drives a byte-wide one-time-programmable memory through the adaptive page-write algorithm. A page is four bytes sharing every address bit above the lowest two. For each page the sequencer first loads the four bytes into the device's page buffer. During this load the chip stays deselected, the data bus is driven, and each byte is captured by a low strobe on the output-enable pin. A single program pulse then writes the whole page. The sequencer reads the four bytes back and compares them with the expected image. It repeats the pulse until they all match or the retry limit is reached.

Once a page verifies after n pulses, one extra overprogram pulse n times the base length is applied and the next page is started. After the last page the supply flag returns to read levels and every address is read once more and compared. The final result is reported on a one-cycle done strobe, with pass and fail levels held until the next start.

Expected data comes from a fetch port that returns the byte for the presented address in the same cycle. All pin timings (strobe width, setup and hold gaps, base pulse length, supply settling) are given in nanoseconds and turned into clock counts from a clock-frequency parameter.

Top module: `otp_page_seq`

## Requirements
- R1: After reset done, pass, fail, mem_dq_oe and prog_supply are 0 and mem_ce_n, mem_oe_n and mem_pgm_n are 1.
- R2: For each page the load phase makes four strobes with mem_addr[1:0] stepping 0, 1, 2, 3 while mem_addr above bit 1 holds the page. Each strobe holds mem_oe_n low for at least the latch time with mem_ce_n high, mem_pgm_n high, and mem_dq_oe high driving the fetched byte of that address.
- R3: Each base program pulse holds mem_pgm_n low for exactly the base pulse length, with mem_ce_n low, mem_oe_n high, mem_dq_oe low and prog_supply high.
- R4: The verify pass reads the four page bytes with mem_ce_n and mem_oe_n low and mem_dq_oe low. A mismatch in any single byte causes another base pulse.
- R5: A page gets at most MAX_TRY base pulses. If the verify after the last allowed pulse still mismatches, the run ends with fail set and no further pulse on any page.
- R6: A page that verifies after n base pulses receives exactly one overprogram pulse of n times the base length, and no further pulse.
- R7: After the overprogram pulse the next page is loaded. After the last page prog_supply drops, every address is read once with mem_pgm_n high, and the run passes only if every byte matches the fetch port.
- R8: done is a one-cycle pulse at which exactly one of pass and fail is 1. Both keep their value after done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (sampled when idle) |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run succeeded, held until next start |
| fail | output | 1 | Run failed, held until next start |
| fetch_addr | output | ADDR_W | Address whose expected byte is requested |
| fetch_data | input | DATA_W | Expected byte for fetch_addr, same cycle |
| mem_addr | output | ADDR_W | Device address pins |
| mem_dq_out | output | DATA_W | Data driven toward the device |
| mem_dq_in | input | DATA_W | Data read from the device |
| mem_dq_oe | output | 1 | Enable for mem_dq_out onto the bus |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable / latch strobe, active low |
| mem_pgm_n | output | 1 | Device program pulse, active low |
| prog_supply | output | 1 | 1 requests programming supply levels, 0 read levels |

## Verification
The hardest situations to reach are the retry limit and the single-byte retry. Both need a device that holds off one byte of a page for a chosen number of pulses. The bench's device model therefore stores each latched page and returns the programmed byte only once the pulse count for that page reaches a per-byte threshold computed from the run's scenario. This lets one run lag a single byte, another sit exactly on the limit, and another exceed it by one. A separate run corrupts one byte only at read supply levels, so that only the final read pass can catch it.

// File: rtl/otp_pg_pkg.sv
package otp_pg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SUP, ST_LSET, ST_LSTB, ST_LHLD,
      ST_PSET, ST_PULSE, ST_PREC, ST_VRD, ST_VEVAL,
      ST_RSUP, ST_RRD, ST_REVAL
   } seq_st_e;

   // Round a duration up to whole clock cycles, never below one.
   function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
      longint unsigned c;
      c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return 32'(c);
   endfunction

endpackage

// File: rtl/otp_pg_timer.sv
module otp_pg_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (ld)         cnt <= ld_val;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/otp_pg_addr.sv
module otp_pg_addr #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_step,
   input  logic              page_step,
   input  logic              lin_step,
   output logic [ADDR_W-1:0] addr,
   output logic              byte_last,
   output logic              page_last,
   output logic              addr_last
);
   localparam int PAGE_W = ADDR_W - 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr <= '0;
      else if (clr)       addr <= '0;
      else if (byte_step) addr[1:0] <= addr[1:0] + 2'd1;
      else if (page_step) addr <= {addr[ADDR_W-1:2] + PAGE_W'(1), 2'b00};
      else if (lin_step)  addr <= addr + ADDR_W'(1);
   end

   assign byte_last = &addr[1:0];
   assign page_last = &addr[ADDR_W-1:2];
   assign addr_last = &addr;

   // R2
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_step && !clr) |=> $stable(addr[ADDR_W-1:2]));
endmodule

// File: rtl/otp_pg_cmp.sv
module otp_pg_cmp #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stb,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] got,
   input  logic [DATA_W-1:0] want,
   output logic              all_ok
);
   logic [3:0] bad;

   for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       bad[b] <= 1'b0;
         else if (clr)                                     bad[b] <= 1'b0;
         else if (stb && idx == 2'(b) && got != want)      bad[b] <= 1'b1;
      end
   end

   assign all_ok = ~|bad;

   // R4
   mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !clr && got != want) |=> !all_ok);
endmodule

// File: rtl/otp_page_seq.sv
module otp_page_seq #(
   parameter int          ADDR_W      = 17,
   parameter int          DATA_W      = 8,
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned T_HOLD_NS   = 2000,
   parameter int unsigned T_LATCH_NS  = 1000,
   parameter int unsigned T_PW_NS     = 200_000,
   parameter int unsigned T_SUPPLY_NS = 2000,
   parameter int unsigned MAX_TRY     = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0] fetch_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_pgm_n,
   output logic              prog_supply
);
   import otp_pg_pkg::*;

   localparam int unsigned HOLD_C = ns2cyc(64'(T_HOLD_NS),   64'(CLK_HZ));
   localparam int unsigned LAT_C  = ns2cyc(64'(T_LATCH_NS),  64'(CLK_HZ));
   localparam int unsigned PW_C   = ns2cyc(64'(T_PW_NS),     64'(CLK_HZ));
   localparam int unsigned SUP_C  = ns2cyc(64'(T_SUPPLY_NS), 64'(CLK_HZ));
   localparam int          TMR_W  = $clog2(PW_C * MAX_TRY + HOLD_C + LAT_C + SUP_C + 1);
   localparam int          TRY_W  = $clog2(MAX_TRY + 1);

   localparam logic [TMR_W-1:0] HOLD_V = TMR_W'(HOLD_C - 1);
   localparam logic [TMR_W-1:0] LAT_V  = TMR_W'(LAT_C - 1);
   localparam logic [TMR_W-1:0] PW_V   = TMR_W'(PW_C - 1);
   localparam logic [TMR_W-1:0] SUP_V  = TMR_W'(SUP_C - 1);

   if (ADDR_W < 3 || DATA_W < 1 || MAX_TRY < 1 || CLK_HZ == 0) begin : g_bad_cfg
      $error("otp_page_seq: unsupported parameter set");
   end

   seq_st_e          st, st_nx;
   logic [TRY_W-1:0] tries;
   logic             over;
   logic             zero, page_ok;
   logic             byte_last, page_last, addr_last;
   logic [ADDR_W-1:0] addr;
   logic             ld;
   logic [TMR_W-1:0] ld_val, over_v;
   logic             a_clr, a_byte, a_page, a_lin;
   logic             c_clr, c_stb;
   logic             fin, fin_ok;
   logic             t_clr, t_inc, ov_set, ov_clr, ps_set, ps_clr;

   otp_pg_timer #(.W(TMR_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .zero(zero));

   otp_pg_addr #(.ADDR_W(ADDR_W)) adr_i (
      .clk(clk), .rst_n(rst_n), .clr(a_clr), .byte_step(a_byte),
      .page_step(a_page), .lin_step(a_lin), .addr(addr),
      .byte_last(byte_last), .page_last(page_last), .addr_last(addr_last));

   otp_pg_cmp #(.DATA_W(DATA_W)) cmp_i (
      .clk(clk), .rst_n(rst_n), .clr(c_clr), .stb(c_stb), .idx(addr[1:0]),
      .got(mem_dq_in), .want(fetch_data), .all_ok(page_ok));

   assign over_v = TMR_W'(tries) * TMR_W'(PW_C) - TMR_W'(1);

   always_comb begin
      st_nx  = st;
      ld     = 1'b0;
      ld_val = HOLD_V;
      a_clr  = 1'b0; a_byte = 1'b0; a_page = 1'b0; a_lin = 1'b0;
      c_clr  = 1'b0; c_stb  = 1'b0;
      fin    = 1'b0; fin_ok = 1'b0;
      t_clr  = 1'b0; t_inc  = 1'b0;
      ov_set = 1'b0; ov_clr = 1'b0;
      ps_set = 1'b0; ps_clr = 1'b0;
      unique case (st)
         ST_IDLE: if (start) begin
            st_nx = ST_SUP; ld = 1'b1; ld_val = SUP_V;
            a_clr = 1'b1; ps_set = 1'b1; t_clr = 1'b1; ov_clr = 1'b1;
         end
         ST_SUP: if (zero) begin
            st_nx = ST_LSET; ld = 1'b1;
         end
         ST_LSET: if (zero) begin
            st_nx = ST_LSTB; ld = 1'b1; ld_val = LAT_V;
         end
         ST_LSTB: if (zero) begin
            st_nx = ST_LHLD; ld = 1'b1;
         end
         ST_LHLD: if (zero) begin
            a_byte = 1'b1; ld = 1'b1;
            st_nx  = byte_last ? ST_PSET : ST_LSET;
         end
         ST_PSET: if (zero) begin
            st_nx = ST_PULSE; ld = 1'b1; ld_val = over ? over_v : PW_V;
         end
         ST_PULSE: if (zero) begin
            st_nx = ST_PREC; ld = 1'b1; t_inc = !over;
         end
         ST_PREC: if (zero) begin
            if (!over) begin
               st_nx = ST_VRD; ld = 1'b1; c_clr = 1'b1;
            end else if (page_last) begin
               st_nx = ST_RSUP; ld = 1'b1; ld_val = SUP_V; a_clr = 1'b1; ps_clr = 1'b1;
            end else begin
               st_nx = ST_LSET; ld = 1'b1; a_page = 1'b1; t_clr = 1'b1; ov_clr = 1'b1;
            end
         end
         ST_VRD: if (zero) begin
            c_stb = 1'b1; a_byte = 1'b1;
            if (byte_last) st_nx = ST_VEVAL;
            else           ld = 1'b1;
         end
         ST_VEVAL: begin
            if (page_ok) begin
               st_nx = ST_PSET; ov_set = 1'b1; ld = 1'b1;
            end else if (tries == TRY_W'(MAX_TRY)) begin
               st_nx = ST_IDLE; fin = 1'b1;
            end else begin
               st_nx = ST_PSET; ld = 1'b1;
            end
         end
         ST_RSUP: if (zero) begin
            st_nx = ST_RRD; ld = 1'b1; c_clr = 1'b1;
         end
         ST_RRD: if (zero) begin
            c_stb = 1'b1;
            if (addr_last) st_nx = ST_REVAL;
            else begin a_lin = 1'b1; ld = 1'b1; end
         end
         ST_REVAL: begin
            st_nx = ST_IDLE; fin = 1'b1; fin_ok = page_ok;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         tries       <= '0;
         over        <= 1'b0;
         prog_supply <= 1'b0;
         done        <= 1'b0;
         pass        <= 1'b0;
         fail        <= 1'b0;
      end else begin
         st   <= st_nx;
         done <= fin;
         if (t_clr)      tries <= '0;
         else if (t_inc) tries <= tries + TRY_W'(1);
         if (ov_clr)      over <= 1'b0;
         else if (ov_set) over <= 1'b1;
         if (ps_set)             prog_supply <= 1'b1;
         else if (ps_clr || fin) prog_supply <= 1'b0;
         if (st == ST_IDLE && start) begin
            pass <= 1'b0;
            fail <= 1'b0;
         end else if (fin) begin
            pass <= fin_ok;
            fail <= !fin_ok;
         end
      end
   end

   always_comb begin
      mem_ce_n  = 1'b1;
      mem_oe_n  = 1'b1;
      mem_pgm_n = 1'b1;
      mem_dq_oe = 1'b0;
      unique case (st)
         ST_LSET, ST_LHLD:            mem_dq_oe = 1'b1;
         ST_LSTB:                     begin mem_dq_oe = 1'b1; mem_oe_n = 1'b0; end
         ST_PSET, ST_PREC, ST_VEVAL:  mem_ce_n = 1'b0;
         ST_PULSE:                    begin mem_ce_n = 1'b0; mem_pgm_n = 1'b0; end
         ST_VRD, ST_RRD:              begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
         default: ;
      endcase
   end

   assign mem_addr   = addr;
   assign fetch_addr = addr;
   assign mem_dq_out = fetch_data;

   // R3
   pulse_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && !mem_dq_oe && prog_supply));
   // R4
   read_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_oe_n) |-> (!mem_dq_oe && mem_pgm_n));
   // R2
   latch_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_supply && mem_ce_n && !mem_oe_n) |-> (mem_dq_oe && mem_pgm_n));
   // R5
   try_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= TRY_W'(MAX_TRY));
   // R7
   read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_supply |-> mem_pgm_n);
   // R8
   result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass ^ fail));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/otp_page_seq_tb.sv
`timescale 1ns/1ps
module otp_page_seq_tb_top;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int LAT = 2;
   localparam int HOLD = 3;
   localparam int PW = 10;
   localparam int LIMIT = 25;
   localparam int NPG = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, pass, fail;
   logic [AW-1:0] fetch_addr, mem_addr;
   logic [DW-1:0] fetch_data, mem_dq_out;
   logic [DW-1:0] mem_dq_in = 8'hFF;
   logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, prog_supply;

   always #5 clk = ~clk;

   otp_page_seq #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(100_000_000), .T_HOLD_NS(30),
      .T_LATCH_NS(20), .T_PW_NS(100), .T_SUPPLY_NS(50), .MAX_TRY(LIMIT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .fail(fail),
      .fetch_addr(fetch_addr), .fetch_data(fetch_data), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
      .prog_supply(prog_supply));

   int n_chk = 0;
   int n_fail = 0;
   int mode = 0;
   int seed = 37;
   bit corrupt = 1'b0;
   bit hung = 1'b0;
   logic [7:0] lat_buf [4];
   logic [7:0] stored [16];
   int pulses [NPG];
   int lat_idx = 0;
   bit seen [16];
   int oe_low = 0;
   int pgm_low = 0;
   logic oe_p = 1'b1;
   logic pgm_p = 1'b1;

   always_comb fetch_data = 8'(((int'(fetch_addr) * seed) + 3) & 127);

   function automatic logic [7:0] expd(int a);
      return 8'(((a * seed) + 3) & 127);
   endfunction

   // Pulses a byte needs before it reads back programmed.
   function automatic int need(int p, int b);
      case (mode)
         0: return 1 + (p * 3) % 4 + ((p == 1 && b == 3) ? 2 : 0);
         1: return (p == 2) ? LIMIT : 1;
         2: return (p == 1 && b == 0) ? LIMIT + 1 : 2;
         default: return 1;
      endcase
   endfunction

   function automatic int kmax(int p);
      int m = 0;
      for (int b = 0; b < 4; b++) if (need(p, b) > m) m = need(p, b);
      return m;
   endfunction

   function automatic logic [7:0] model_rd(int a);
      logic [7:0] v;
      v = (pulses[a / 4] >= need(a / 4, a % 4)) ? stored[a] : 8'hFF;
      if (!prog_supply && corrupt && a == 9) v = v ^ 8'h01;
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp, string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Device model and pin monitor, away from the active edge.
   always @(negedge clk) begin
      int p, k;
      if (rst_n) begin
         if (!mem_oe_n && mem_ce_n && prog_supply) oe_low++;
         if (mem_oe_n && !oe_p && mem_ce_n && prog_supply) begin
            chk(oe_low >= LAT, "R2", oe_low, LAT, "latch strobe width");
            chk(int'(mem_addr[1:0]) == lat_idx, "R2", int'(mem_addr[1:0]), lat_idx, "latch byte order");
            chk(mem_dq_oe && mem_dq_out == expd(int'(mem_addr)), "R2", int'(mem_dq_out),
                int'(expd(int'(mem_addr))), "latch data");
            lat_buf[mem_addr[1:0]] = mem_dq_out;
            lat_idx++;
            oe_low = 0;
         end
         if (!mem_pgm_n) pgm_low++;
         if (mem_pgm_n && !pgm_p) begin
            p = int'(mem_addr[AW-1:2]);
            pulses[p]++;
            if (pulses[p] == 1) begin
               chk(lat_idx == 4, "R2", lat_idx, 4, "bytes latched before pulse");
               for (int b = 0; b < 4; b++) stored[p * 4 + b] = lat_buf[b];
               lat_idx = 0;
            end
            k = kmax(p);
            if (pulses[p] <= k && pulses[p] <= LIMIT)
               chk(pgm_low == PW, "R3", pgm_low, PW, "base pulse width");
            else if (pulses[p] == k + 1 && k <= LIMIT)
               chk(pgm_low == k * PW, "R6", pgm_low, k * PW, "overprogram width");
            else
               chk(1'b0, "R5", pulses[p], k, "pulse beyond limit");
            pgm_low = 0;
         end
         if (!mem_ce_n && !mem_oe_n) begin
            chk(!mem_dq_oe, "R4", int'(mem_dq_oe), 0, "bus released on read");
            if (!prog_supply) seen[mem_addr] = 1'b1;
         end
         oe_p = mem_oe_n;
         pgm_p = mem_pgm_n;
         mem_dq_in <= model_rd(int'(mem_addr));
      end
   end

   task automatic run(int m, int sd, bit cor, bit exp_pass, int fail_pg, string req);
      int cyc = 0;
      int exp_n;
      int n_seen = 0;
      mode = m; seed = sd; corrupt = cor;
      for (int i = 0; i < 16; i++) begin stored[i] = 8'hFF; seen[i] = 1'b0; end
      for (int i = 0; i < NPG; i++) pulses[i] = 0;
      lat_idx = 0; oe_low = 0; pgm_low = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
      if (!done) begin
         hung = 1'b1;
         chk(1'b0, req, cyc, 40000, "watchdog expired");
         return;
      end
      chk(pass == exp_pass, "R8", int'(pass), int'(exp_pass), {req, " pass at done"});
      chk(fail == !exp_pass, "R8", int'(fail), int'(!exp_pass), {req, " fail at done"});
      for (int p = 0; p < NPG; p++) begin
         if (fail_pg < 0 || p < fail_pg) exp_n = kmax(p) + 1;
         else if (p == fail_pg) exp_n = LIMIT;
         else exp_n = 0;
         chk(pulses[p] == exp_n, (fail_pg >= 0) ? "R5" : "R6", pulses[p], exp_n, {req, " pulses per page"});
      end
      if (fail_pg < 0) begin
         for (int i = 0; i < 16; i++) n_seen += int'(seen[i]);
         chk(n_seen == 16, "R7", n_seen, 16, {req, " final read coverage"});
      end
      @(negedge clk);
      chk(!done, "R8", int'(done), 0, "done lasts one cycle");
      chk(pass == exp_pass && fail == !exp_pass, "R8", int'(pass), int'(exp_pass), "result held");
      chk(!prog_supply, "R7", int'(prog_supply), 0, "supply back to read levels");
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!done && !pass && !fail, "R1", int'({done, pass, fail}), 0, "result outputs");
      chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1", int'({mem_ce_n, mem_oe_n, mem_pgm_n}), 7, "control pins");
      chk(!mem_dq_oe && !prog_supply, "R1", int'({mem_dq_oe, prog_supply}), 0, "bus and supply");
      // R4: one byte of page 1 lags, forcing extra pulses
      if (!hung) run(0, 37, 1'b0, 1'b1, -1, "R4 mixed");
      // R5: page 2 needs exactly the limit
      if (!hung) run(1, 91, 1'b0, 1'b1, -1, "R5 at limit");
      // R5: page 1 needs one more than the limit
      if (!hung) run(2, 53, 1'b0, 1'b0, 1, "R5 over limit");
      // R7: final read pass catches a corrupted byte
      if (!hung) run(3, 29, 1'b1, 1'b0, -1, "R7 read mismatch");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule